// File: doc/BRIEF.md
# Receive Buffer Scatter Engine with Trailing CRC

This block takes an incoming frame, announced by a start pulse carrying its payload length and then delivered one byte at a time, and spreads it over a ring of receive buffer descriptors held in memory. The payload is followed in memory by a 4-byte CRC-32. The block computes the CRC serially as the payload arrives. Each buffer takes at most a programmable number of bytes, so the stored frame can span several descriptors. The CRC can also be split across the end of one buffer and the start of the next.

When a descriptor is finished, the block writes its status word back. This word holds the byte count and the updated flags. The block also pulses a buffer-done or frame-done interrupt cause. Frames that are too long are flagged against a soft limit given as an input. They are also cut short at a hard maximum frame size, which is a parameter.

A receive-active flag decides whether a new frame is accepted. This flag is recomputed from the empty bit of the next descriptor after every frame and whenever software requests activation. All memory traffic uses a single request/acknowledge port. This port carries 32-bit word reads, 32-bit word writes and single-byte writes.

Top module: `rx_desc_scatter`

## Requirements
- R1: While `rx_active` is low, a `frm_start` pulse is refused. The block pulses `rx_refused`, makes no memory request and never raises `frm_ready` for that frame.
- R2: The stored size of a frame is the payload length plus 4. The payload bytes come first. They are followed by the CRC-32 of all payload bytes: reflected polynomial 0xEDB88320, initial value all ones, result inverted. The CRC bytes are stored most significant byte first.
- R3: If payload length + 4 exceeds `MAX_FRAME`, the stored size becomes `MAX_FRAME`. Payload bytes beyond `MAX_FRAME`-4 are consumed but not stored, and they still count in the CRC. The final descriptor then carries both the truncated flag (flag bit 0) and the length-error flag (flag bit 5).
- R4: If the stored size, after any clamping, exceeds `cfg_len_limit`, the final descriptor carries the length-error flag (flag bit 5).
- R5: Each buffer receives at most `cfg_buf_size & 16'h3FF0` bytes. Bits outside 13:4 of the setting are ignored. No byte is written past that count.
- R6: When fewer than 4 bytes of the stored frame remain for the next buffer, the CRC bytes fill the tail of the current buffer. The CRC may therefore be split over consecutive buffers.
- R7: Descriptor layout: word 0 is {flags[15:0], length[15:0]} and word 1 is the buffer address. Flag bit 15 is empty, bit 13 is wrap and bit 11 is last. A used descriptor gets its empty bit cleared and its byte count written, and its other flag bits are kept. If a descriptor is read with empty clear, the frame stops and `lost_eof` pulses. The rest of the frame's bytes are then drained.
- R8: Only the final descriptor gets the last flag and any error flags, and it pulses `irq_rxf`. Each earlier descriptor pulses `irq_rxb`. In enhanced mode (`cfg_enhanced`=1), both pulses happen only if bit 23 of descriptor word 2 is set.
- R9: After a descriptor with the wrap flag, the next descriptor address is `cfg_ring_base`. Otherwise the address advances by 8 bytes, or by 16 bytes in enhanced mode.
- R10: After every frame, `rx_active` is set to the empty bit of the next descriptor. An `act_req` while enabled and inactive does the same. While `cfg_enable` is low and no frame is in progress, `rx_active` is low and the ring pointer returns to `cfg_ring_base`. Reset clears `rx_active`.
- R11: A memory request holds `mem_req` and `mem_addr` until `mem_ack`. No stream byte is accepted while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Receiver enabled; low rewinds the ring |
| cfg_enhanced | input | 1 | Enhanced descriptors (16-byte stride, interrupt option word) |
| cfg_ring_base | input | AW | Ring start address |
| cfg_buf_size | input | 16 | Buffer size setting, bits 13:4 used |
| cfg_len_limit | input | 16 | Soft frame length limit for length-error |
| act_req | input | 1 | Request to re-check the current descriptor |
| frm_start | input | 1 | Frame start pulse |
| frm_len | input | 16 | Payload length of the frame being started |
| frm_valid | input | 1 | Stream byte valid |
| frm_data | input | 8 | Stream byte |
| frm_ready | output | 1 | Stream byte accepted this cycle when valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Write is a single byte (`mem_wdata[7:0]`) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| rx_active | output | 1 | Ready to accept a frame |
| irq_rxf | output | 1 | Frame-done cause pulse |
| irq_rxb | output | 1 | Buffer-done cause pulse |
| lost_eof | output | 1 | Frame cut short by a full descriptor |
| rx_refused | output | 1 | Frame refused pulse |

## Verification
The assertions assume three things. The memory side answers every request with exactly one `mem_ack` and presents read data in that cycle. A frame start arrives only when the block is idle, and the byte count that follows matches `frm_len`. The buffer-size setting keeps at least one bit of 13:4 set. The stimulus respects all three: the memory model acknowledges one cycle after each request, the bench waits out every frame before starting the next, it sends exactly the announced bytes, and every buffer setting used (including ones with stray high and low bits) leaves a nonzero size.

// File: rtl/rds_pkg.sv
package rds_pkg;

    localparam int LENW    = 16;
    // flag positions within the upper half of descriptor word 0
    localparam int F_EMPTY = 15;
    localparam int F_WRAP  = 13;
    localparam int F_LAST  = 11;
    localparam int F_LONG  = 5;
    localparam int F_TRUNC = 0;
    // interrupt enable in the enhanced option word
    localparam int OPT_IRQ = 23;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DESC0,
        ST_DESC1,
        ST_DESC2,
        ST_MOVE,
        ST_WRITE,
        ST_WBACK,
        ST_DRAIN,
        ST_ACT
    } rds_state_e;

    typedef struct packed {
        logic [LENW-1:0] stored;
        logic [LENW-1:0] data_lim;
        logic            trunc;
        logic            long_len;
    } rds_size_t;

    // one reflected CRC-32 byte step
    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rds_len_calc.sv
module rds_len_calc
    import rds_pkg::*;
#(
    parameter int MAX_FRAME = 2032
) (
    input  logic [LENW-1:0] len,
    input  logic [LENW-1:0] limit,
    output rds_size_t       sz
);
    localparam logic [LENW:0] MAXW = (LENW+1)'(MAX_FRAME);

    logic [LENW:0] total;

    always_comb begin
        total       = {1'b0, len} + (LENW+1)'(4);
        sz.trunc    = total > MAXW;
        sz.stored   = sz.trunc ? MAXW[LENW-1:0] : total[LENW-1:0];
        sz.long_len = sz.trunc || (sz.stored > limit);
        sz.data_lim = sz.stored - LENW'(4);
    end
endmodule

// File: rtl/rds_crc32.sv
module rds_crc32
    import rds_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '1;
        else if (en)    acc <= crc_step(acc, din);
    end

    assign crc = ~acc;
endmodule

// File: rtl/rds_ring_ptr.sv
module rds_ring_ptr #(
    parameter int AW         = 32,
    parameter int STRIDE_LEG = 8,
    parameter int STRIDE_ENH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic          enh,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP_L = AW'(STRIDE_LEG);
    localparam logic [AW-1:0] STEP_E = AW'(STRIDE_ENH);

    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (load)    ptr <= base;
        else if (advance) ptr <= wrap ? base : ptr + (enh ? STEP_E : STEP_L);
    end
endmodule

// File: rtl/rx_desc_scatter.sv
module rx_desc_scatter
    import rds_pkg::*;
#(
    parameter int AW         = 32,
    parameter int MAX_FRAME  = 2032,
    parameter int STRIDE_LEG = 8,
    parameter int STRIDE_ENH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_enable,
    input  logic          cfg_enhanced,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic [15:0]   cfg_buf_size,
    input  logic [15:0]   cfg_len_limit,
    input  logic          act_req,
    input  logic          frm_start,
    input  logic [15:0]   frm_len,
    input  logic          frm_valid,
    input  logic [7:0]    frm_data,
    output logic          frm_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          rx_active,
    output logic          irq_rxf,
    output logic          irq_rxb,
    output logic          lost_eof,
    output logic          rx_refused
);
    localparam int EMPTY_W = 16 + F_EMPTY;

    rds_state_e      st;
    rds_size_t       sz_now, sz_q;
    logic [15:0]     dflags, flags_wb;
    logic [AW-1:0]   bufptr, ptr;
    logic [LENW-1:0] boff, pos, consumed, len_q, bufmax, crc_k;
    logic [7:0]      wbyte, crc_byte;
    logic [31:0]     crc_val;
    logic            opt_irq, take, last_buf, irq_on;

    assign bufmax   = {2'b00, cfg_buf_size[13:4], 4'b0000};
    assign take     = frm_valid && frm_ready;
    assign last_buf = (pos == sz_q.stored);
    assign irq_on   = !cfg_enhanced || opt_irq;
    assign crc_k    = pos - sz_q.data_lim;

    rds_len_calc #(.MAX_FRAME(MAX_FRAME)) u_len (
        .len   (frm_len),
        .limit (cfg_len_limit),
        .sz    (sz_now)
    );

    rds_crc32 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (st == ST_IDLE),
        .en  (take),
        .din (frm_data),
        .crc (crc_val)
    );

    rds_ring_ptr #(.AW(AW), .STRIDE_LEG(STRIDE_LEG), .STRIDE_ENH(STRIDE_ENH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (st == ST_IDLE && !cfg_enable),
        .advance (st == ST_WBACK && mem_ack),
        .wrap    (dflags[F_WRAP]),
        .enh     (cfg_enhanced),
        .base    (cfg_ring_base),
        .ptr     (ptr)
    );

    always_comb begin
        case (crc_k[1:0])
            2'd0:    crc_byte = crc_val[31:24];
            2'd1:    crc_byte = crc_val[23:16];
            2'd2:    crc_byte = crc_val[15:8];
            default: crc_byte = crc_val[7:0];
        endcase
    end

    always_comb begin
        flags_wb          = dflags;
        flags_wb[F_EMPTY] = 1'b0;
        if (last_buf) begin
            flags_wb[F_LAST] = 1'b1;
            if (sz_q.long_len) flags_wb[F_LONG]  = 1'b1;
            if (sz_q.trunc)    flags_wb[F_TRUNC] = 1'b1;
        end
    end

    always_comb begin
        frm_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = ptr;
        mem_wdata = 32'h0;
        case (st)
            ST_MOVE:  frm_ready = (pos < sz_q.data_lim) || (consumed < len_q);
            ST_DRAIN: frm_ready = consumed < len_q;
            ST_DESC0, ST_ACT: mem_req = 1'b1;
            ST_DESC1: begin mem_req = 1'b1; mem_addr = ptr + AW'(4); end
            ST_DESC2: begin mem_req = 1'b1; mem_addr = ptr + AW'(8); end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = bufptr + AW'(boff);
                mem_wdata = {24'h0, wbyte};
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {flags_wb, boff};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rx_active  <= 1'b0;
            irq_rxf    <= 1'b0;
            irq_rxb    <= 1'b0;
            lost_eof   <= 1'b0;
            rx_refused <= 1'b0;
            sz_q       <= '0;
            dflags     <= '0;
            bufptr     <= '0;
            boff       <= '0;
            pos        <= '0;
            consumed   <= '0;
            len_q      <= '0;
            wbyte      <= '0;
            opt_irq    <= 1'b0;
        end else begin
            irq_rxf    <= 1'b0;
            irq_rxb    <= 1'b0;
            lost_eof   <= 1'b0;
            rx_refused <= 1'b0;
            if (take) consumed <= consumed + LENW'(1);
            case (st)
                ST_IDLE: begin
                    if (!cfg_enable) begin
                        rx_active <= 1'b0;
                    end else if (frm_start) begin
                        if (rx_active) begin
                            len_q    <= frm_len;
                            sz_q     <= sz_now;
                            pos      <= '0;
                            consumed <= '0;
                            st       <= ST_DESC0;
                        end else begin
                            rx_refused <= 1'b1;
                        end
                    end else if (act_req && !rx_active) begin
                        st <= ST_ACT;
                    end
                end
                ST_DESC0: if (mem_ack) begin
                    if (!mem_rdata[EMPTY_W]) begin
                        lost_eof <= 1'b1;
                        st       <= ST_DRAIN;
                    end else begin
                        dflags <= mem_rdata[31:16];
                        st     <= ST_DESC1;
                    end
                end
                ST_DESC1: if (mem_ack) begin
                    bufptr  <= mem_rdata[AW-1:0];
                    boff    <= '0;
                    opt_irq <= 1'b1;
                    st      <= cfg_enhanced ? ST_DESC2 : ST_MOVE;
                end
                ST_DESC2: if (mem_ack) begin
                    opt_irq <= mem_rdata[OPT_IRQ];
                    st      <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (pos < sz_q.data_lim) begin
                        if (take) begin
                            wbyte <= frm_data;
                            st    <= ST_WRITE;
                        end
                    end else if (consumed == len_q) begin
                        wbyte <= crc_byte;
                        st    <= ST_WRITE;
                    end
                end
                ST_WRITE: if (mem_ack) begin
                    pos  <= pos + LENW'(1);
                    boff <= boff + LENW'(1);
                    if ((pos + LENW'(1) == sz_q.stored) || (boff + LENW'(1) == bufmax))
                        st <= ST_WBACK;
                    else
                        st <= ST_MOVE;
                end
                ST_WBACK: if (mem_ack) begin
                    if (irq_on) begin
                        if (last_buf) irq_rxf <= 1'b1;
                        else          irq_rxb <= 1'b1;
                    end
                    st <= last_buf ? ST_ACT : ST_DESC0;
                end
                ST_DRAIN: if (consumed == len_q) st <= ST_ACT;
                ST_ACT: if (mem_ack) begin
                    rx_active <= mem_rdata[EMPTY_W];
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rds_chk.sv
module rds_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_refused,
    input logic          rx_active,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          irq_rxf,
    input logic          irq_rxb,
    input logic          lost_eof,
    input logic          frm_ready
);
    // R1
    refuse_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        rx_refused |-> !rx_active);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R11
    stream_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        frm_ready |-> !mem_req);

    // R8
    cause_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_rxf && irq_rxb));

    // R7
    lost_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        lost_eof |-> !irq_rxf);

    // R10
    active_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> $past(mem_ack && !mem_we));
endmodule

bind rx_desc_scatter rds_chk #(.AW(AW)) u_rds_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_refused (rx_refused),
    .rx_active  (rx_active),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .irq_rxf    (irq_rxf),
    .irq_rxb    (irq_rxb),
    .lost_eof   (lost_eof),
    .frm_ready  (frm_ready)
);

// File: tb/rx_desc_scatter_tb.sv
`timescale 1ns/1ps
module rx_desc_scatter_tb;
    localparam int MAXF = 48;
    localparam logic [15:0] FE = 16'h8000, FW = 16'h2000, FL = 16'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0, cfg_enhanced = 1'b0;
    logic [31:0] cfg_ring_base = 32'h0;
    logic [15:0] cfg_buf_size = 16'h40, cfg_len_limit = 16'd2000;
    logic        act_req = 1'b0, frm_start = 1'b0, frm_valid = 1'b0;
    logic [15:0] frm_len = 16'h0;
    logic [7:0]  frm_data = 8'h0;
    logic        frm_ready, mem_req, mem_we, mem_byte, mem_ack, rx_active;
    logic        irq_rxf, irq_rxb, lost_eof, rx_refused;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    rx_desc_scatter #(.MAX_FRAME(MAXF)) u_dut (.*);

    logic [7:0] mem [0:1023];
    logic [7:0] payload [0:63];
    int nchk = 0, nbad = 0;
    int n_rxf = 0, n_rxb = 0, n_lost = 0, n_ref = 0, n_acc = 0, n_rdy = 0;
    bit done = 0;

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (mem_byte) mem[mem_addr[9:0]] <= mem_wdata[7:0];
                else begin
                    mem[mem_addr[9:0]]        <= mem_wdata[7:0];
                    mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
                    mem[mem_addr[9:0] + 10'd2] <= mem_wdata[23:16];
                    mem[mem_addr[9:0] + 10'd3] <= mem_wdata[31:24];
                end
            end else
                mem_rdata <= {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                              mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
        end else mem_ack <= 1'b0;
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (irq_rxf)           n_rxf++;
            if (irq_rxb)           n_rxb++;
            if (lost_eof)          n_lost++;
            if (rx_refused)        n_ref++;
            if (mem_req && mem_ack) n_acc++;
            if (frm_ready)         n_rdy++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic wr32(input int a, input logic [31:0] d);
        mem[a] = d[7:0]; mem[a+1] = d[15:8]; mem[a+2] = d[23:16]; mem[a+3] = d[31:24];
    endtask

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ payload[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        return ~c;
    endfunction

    task automatic zero_counts();
        n_rxf = 0; n_rxb = 0; n_lost = 0; n_ref = 0; n_acc = 0; n_rdy = 0;
    endtask

    task automatic ring_init(input bit enh, input bit opt, input int n_empty);
        int stride = enh ? 16 : 8;
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wr32(i*stride, {((i < n_empty) ? FE : 16'h0) | ((i == 7) ? FW : 16'h0), 16'h0});
            wr32(i*stride + 4, 32'h100 + 32'(i*64));
            if (enh) wr32(i*stride + 8, {8'h0, opt, 23'h0});
        end
        @(negedge clk); cfg_enhanced = enh; cfg_enable = 1'b0;
        @(negedge clk); cfg_enable = 1'b1; act_req = 1'b1;
        @(negedge clk); act_req = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_frame(input int len);
        zero_counts();
        @(negedge clk); frm_start = 1'b1; frm_len = 16'(len);
        @(negedge clk); frm_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            frm_valid = 1'b1; frm_data = payload[i];
            while (!frm_ready) @(negedge clk);
            @(negedge clk);
        end
        frm_valid = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic verify(input int len, input int cfg, input int lim, input bit enh, input bit opt);
        int total = len + 4;
        int stored = (total > MAXF) ? MAXF : total;
        bit tr = total > MAXF;
        bit lg = tr || (stored > lim);
        int dl = stored - 4;
        int bm = cfg & 16'h3FF0;
        int stride = enh ? 16 : 8;
        logic [31:0] crc = ref_crc(len);
        int rem = stored, k = 0, nd = 0;
        bit irqs = !enh || opt;
        while (rem > 0) begin
            int n = (rem < bm) ? rem : bm;
            bit last = (rem == n);
            logic [15:0] ef = ((nd == 7) ? FW : 16'h0) |
                              (last ? (FL | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0)) : 16'h0);
            int bad = 0;
            logic [31:0] w0 = rd32(nd*stride);
            chk(w0 == {ef, 16'(n)}, "R7/R3/R4 descriptor status word", w0, {ef, 16'(n)});
            for (int j = 0; j < n; j++) begin
                logic [7:0] e = (k < dl) ? payload[k] : 8'(crc >> (24 - 8*(k - dl)));
                if (mem[256 + nd*64 + j] != e) bad++;
                k++;
            end
            chk(bad == 0, "R2/R6 buffer bytes", bad, 0);
            if (n < 64) chk(mem[256 + nd*64 + n] == 8'h00, "R5 byte past buffer limit",
                            mem[256 + nd*64 + n], 0);
            rem -= n;
            nd++;
        end
        chk(n_rxf == (irqs ? 1 : 0), "R8 frame cause count", n_rxf, irqs ? 1 : 0);
        chk(n_rxb == (irqs ? nd-1 : 0), "R8 buffer cause count", n_rxb, irqs ? nd-1 : 0);
        chk(rd32(nd*stride) == {FE, 16'h0}, "R9 next descriptor untouched", rd32(nd*stride), {FE, 16'h0});
        chk(rx_active == 1'b1, "R10 active after frame", rx_active, 1);
    endtask

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] cfg;
        logic [15:0] lim;
        logic        enh;
        logic        opt;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{16'd20, 16'h0040, 16'd2000, 1'b0, 1'b0},  // one buffer
        '{16'd30, 16'h0010, 16'd2000, 1'b0, 1'b0},  // CRC split 2+2
        '{16'd13, 16'h001F, 16'd2000, 1'b0, 1'b0},  // CRC split 3+1, low bits ignored
        '{16'd40, 16'h0020, 16'd40,   1'b0, 1'b0},  // soft limit length error
        '{16'd50, 16'h0020, 16'd2000, 1'b0, 1'b0},  // hard clamp, truncated
        '{16'd20, 16'hC01C, 16'd2000, 1'b0, 1'b0},  // high bits ignored
        '{16'd0,  16'h0040, 16'd2000, 1'b0, 1'b0},  // CRC only
        '{16'd30, 16'h0010, 16'd2000, 1'b1, 1'b1},  // enhanced, causes enabled
        '{16'd30, 16'h0010, 16'd2000, 1'b1, 1'b0}   // enhanced, causes gated off
    };

    initial begin
        for (int i = 0; i < 64; i++) payload[i] = 8'(i*13 + 5);
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(rx_active == 1'b0, "R10 reset rx_active", rx_active, 0);
        chk(mem_req == 1'b0, "R11 reset mem_req", mem_req, 0);
        chk(frm_ready == 1'b0, "R1 reset frm_ready", frm_ready, 0);

        // R1: refuse when not active
        cfg_enable = 1'b1;
        wr32(0, {FE, 16'h0});
        zero_counts();
        @(negedge clk); frm_start = 1'b1; frm_len = 16'd10;
        @(negedge clk); frm_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_ref == 1, "R1 refused pulse", n_ref, 1);
        chk(n_acc == 0, "R1 no memory access", n_acc, 0);
        chk(n_rdy == 0, "R1 no ready", n_rdy, 0);

        // R10: activate while disabled stays inactive
        cfg_enable = 1'b0;
        @(negedge clk); act_req = 1'b1;
        @(negedge clk); act_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(rx_active == 1'b0, "R10 activate while disabled", rx_active, 0);

        // R10: first descriptor full leaves receiver inactive
        ring_init(1'b0, 1'b0, 0);
        chk(rx_active == 1'b0, "R10 activate on full descriptor", rx_active, 0);
        ring_init(1'b0, 1'b0, 8);
        chk(rx_active == 1'b1, "R10 activate on empty descriptor", rx_active, 1);

        for (int vi = 0; vi < 9; vi++) begin
            vec_t v;
            v = VECS[vi];
            cfg_buf_size = v.cfg; cfg_len_limit = v.lim;
            ring_init(v.enh, v.opt, 8);
            send_frame(int'(v.len));
            verify(int'(v.len), int'(v.cfg), int'(v.lim), v.enh, v.opt);
        end

        // R7: lost end of frame
        cfg_buf_size = 16'h0010; cfg_len_limit = 16'd2000;
        ring_init(1'b0, 1'b0, 1);
        send_frame(30);
        chk(n_lost == 1, "R7 lost pulse", n_lost, 1);
        chk(rd32(0) == 32'h0000_0010, "R7 first descriptor word", rd32(0), 32'h0000_0010);
        chk(rd32(8) == 32'h0, "R7 full descriptor untouched", rd32(8), 0);
        chk(n_rxf == 0 && n_rxb == 1, "R8 causes on lost frame", n_rxf*16 + n_rxb, 1);
        chk(rx_active == 1'b0, "R10 inactive after lost frame", rx_active, 0);

        // R9: wrap back to ring start
        cfg_buf_size = 16'h0010;
        ring_init(1'b0, 1'b0, 8);
        for (int f = 0; f < 8; f++) send_frame(12);
        chk(rd32(56) == {FW | FL, 16'd16}, "R9 wrap descriptor word", rd32(56), {FW | FL, 16'd16});
        chk(rx_active == 1'b0, "R10 inactive after wrap onto used descriptor", rx_active, 0);
        wr32(0, {FE, 16'h0});
        @(negedge clk); act_req = 1'b1;
        @(negedge clk); act_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(rx_active == 1'b1, "R10 reactivated", rx_active, 1);
        send_frame(5);
        chk(rd32(0) == {FL, 16'd9}, "R9 frame lands at ring start", rd32(0), {FL, 16'd9});
        chk(mem[256] == payload[0], "R9 buffer at ring start", mem[256], payload[0]);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule